// File: doc/BRIEF.md
# Serial DAC Host Write Controller

This block drives a three-wire serial converter link from the host side. It also drives two separate active-low strobes: a latch-update strobe and a clear strobe. A 16-bit word arrives on a valid/ready handshake. The block frames it with an active-low select and shifts it out most significant bit first. The receiver samples on the falling edges of the generated serial clock. After the select returns high, the block pulses the update strobe to move the word into the output latch, unless a configuration input holds that strobe low permanently.

A one-cycle clear request produces a low pulse on the clear strobe. If the request arrives while a frame is in flight, it is held until that frame and its update sequence have finished. Every minimum interval of the link is a nanosecond parameter. At elaboration it is turned into a count of system clock cycles by rounding up, with a floor of one cycle. All outputs come straight from flip-flops.

Top module: `sdac_wr_ctrl`

## Requirements
- R1: Each frame carries exactly 16 serial clock falling edges while `dac_sync_n` is low. The bits of `s_data` go out on `dac_sdin` from bit 15 down to bit 0.
- R2: The serial clock high phase lasts at least 60 ns, the low phase at least 60 ns, and each falling-to-falling period at least 140 ns. With a 100 MHz system clock the period is exactly 14 cycles (140 ns).
- R3: `dac_sync_n` falls at least 50 ns before the first serial clock falling edge of a frame. It rises no sooner than 40 ns after the last one. `dac_sclk` is high in every cycle where `dac_sync_n` is high.
- R4: Within a frame, `dac_sdin` changes only in the cycle where `dac_sclk` rises. It is stable for at least 40 ns before each falling edge and for at least 15 ns after it.
- R5: Between two frames, `dac_sync_n` stays high for at least 50 ns.
- R6: With `ldac_hold_low` = 0, each frame is followed by exactly one low pulse on `dac_ldac_n`. The pulse starts at least 5 ns after `dac_sync_n` rises and lasts at least 50 ns. The next `dac_sync_n` fall comes at least 5 ns after it ends.
- R7: With `ldac_hold_low` = 1, `dac_ldac_n` stays at 0 from the cycle after the input is sampled, and no pulse is produced.
- R8: A one-cycle high on `clr_req` produces one low pulse on `dac_clr_n` of at least 50 ns. With a 100 MHz system clock it is exactly 5 cycles (50 ns).
- R9: A word is taken only in a cycle where `s_valid` and `s_ready` are both high. `s_ready` is low from the cycle after acceptance until the frame and its update sequence are done, and a valid word offered while `s_ready` is low is not sent.
- R10: A clear request that arrives during a frame, or in the same cycle as a frame acceptance, waits until the frame and its update pulse are complete. `dac_clr_n` never falls while `dac_sync_n` is low.
- R11: While `rst` is high, `dac_sync_n`, `dac_sclk`, `dac_ldac_n` and `dac_clr_n` are 1 and `s_ready` is 0. `s_ready` becomes 1 in the first cycle after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_valid | input | 1 | Word offered on `s_data` |
| s_data | input | 16 | Word to send, bit 15 goes out first |
| s_ready | output | 1 | Controller can take a word this cycle |
| ldac_hold_low | input | 1 | 1: update strobe held low, no pulse; 0: pulse after each frame |
| clr_req | input | 1 | Request for one clear pulse |
| dac_sync_n | output | 1 | Active-low frame select |
| dac_sclk | output | 1 | Serial clock, idles high |
| dac_sdin | output | 1 | Serial data, changes on serial clock rising edges |
| dac_ldac_n | output | 1 | Active-low latch-update strobe |
| dac_clr_n | output | 1 | Active-low clear strobe |

## Verification
A clear request and a frame acceptance can land in the same cycle. The bench provokes this by raising `clr_req` together with `s_valid` in an idle cycle where `s_ready` is high. The result passes when the word is captured intact by the modelled receiver. The clear pulse must also start only after the select has returned high and the update pulse has ended, and its width must be right. A request injected in the middle of a frame is judged the same way.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SCK_LO,
    ST_SCK_HI,
    ST_POST,
    ST_CLR
  } wr_state_e;

  // Nanoseconds to whole system cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input longint ns, input longint hz);
    longint c;
    c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
    if (c < 1) c = 1;
    return int'(c);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdac_phase_timer.sv
`timescale 1ns/1ps
module sdac_phase_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic [CW-1:0] count,
  output logic          expired
);

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
    end else if (load) begin
      count <= load_val;
    end else if (count != '0) begin
      count <= count - CW'(1);
    end
  end

  assign expired = (count == '0);

endmodule

// File: rtl/sdac_shift_out.sv
`timescale 1ns/1ps
module sdac_shift_out #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);

  logic [W-1:0] sr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q <= '0;
    end else if (load) begin
      sr_q <= din;
    end else if (shift) begin
      sr_q <= {sr_q[W-2:0], 1'b0};
    end
  end

  assign msb = sr_q[W-1];

endmodule

// File: rtl/sdac_wr_ctrl.sv
`timescale 1ns/1ps
module sdac_wr_ctrl
  import sdac_pkg::*;
#(
  parameter int CLK_HZ         = 100_000_000,
  parameter int WORD_W         = 16,
  parameter int T_SCLK_HI_NS   = 60,
  parameter int T_SCLK_LO_NS   = 60,
  parameter int T_SCLK_PER_NS  = 140,
  parameter int T_SYNC_SU_NS   = 50,
  parameter int T_SYNC_HD_NS   = 40,
  parameter int T_SYNC_GAP_NS  = 50,
  parameter int T_DATA_SU_NS   = 40,
  parameter int T_DATA_HD_NS   = 15,
  parameter int T_LDAC_DLY_NS  = 5,
  parameter int T_LDAC_W_NS    = 50,
  parameter int T_LDAC_REC_NS  = 5,
  parameter int T_CLR_W_NS     = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              s_valid,
  input  logic [WORD_W-1:0] s_data,
  output logic              s_ready,
  input  logic              ldac_hold_low,
  input  logic              clr_req,
  output logic              dac_sync_n,
  output logic              dac_sclk,
  output logic              dac_sdin,
  output logic              dac_ldac_n,
  output logic              dac_clr_n
);

  // Phase lengths in system cycles.
  localparam longint HZ = longint'(CLK_HZ);
  localparam int C_HI    = imax(ns_to_cyc(T_SCLK_HI_NS, HZ), ns_to_cyc(T_DATA_SU_NS, HZ));
  localparam int C_LO    = imax(imax(ns_to_cyc(T_SCLK_LO_NS, HZ), ns_to_cyc(T_DATA_HD_NS, HZ)),
                                ns_to_cyc(T_SCLK_PER_NS, HZ) - C_HI);
  localparam int C_SETUP = imax(ns_to_cyc(T_SYNC_SU_NS, HZ), ns_to_cyc(T_DATA_SU_NS, HZ));
  localparam int C_LAST  = imax(C_LO, ns_to_cyc(T_SYNC_HD_NS, HZ));
  localparam int C_GAP   = ns_to_cyc(T_SYNC_GAP_NS, HZ);
  localparam int C_LDD   = ns_to_cyc(T_LDAC_DLY_NS, HZ);
  localparam int C_LDW   = ns_to_cyc(T_LDAC_W_NS, HZ);
  localparam int C_LDR   = ns_to_cyc(T_LDAC_REC_NS, HZ);
  localparam int C_CLR   = ns_to_cyc(T_CLR_W_NS, HZ);
  localparam int C_POST_PULSE = imax(C_GAP, C_LDD + C_LDW + C_LDR);
  localparam int C_POST_HOLD  = C_GAP;

  localparam int CNT_MAX = imax(imax(imax(C_HI, C_LO), imax(C_SETUP, C_LAST)),
                                imax(C_POST_PULSE, C_CLR));
  localparam int CW = $clog2(CNT_MAX + 1);
  localparam int BW = $clog2(WORD_W);

  // The post phase counts down; the update pulse covers these count values.
  localparam int LD_HI_I = C_POST_PULSE - 1 - C_LDD;
  localparam int LD_LO_I = C_POST_PULSE - C_LDD - C_LDW;
  localparam logic [CW-1:0] LD_HI = CW'(LD_HI_I);
  localparam logic [CW-1:0] LD_LO = CW'(LD_LO_I);

  wr_state_e       state_q, state_d;
  logic [CW-1:0]   tmr_cnt, tmr_val, post_cnt_d, post_len_m1, lo_len_m1;
  logic            tmr_load, tmr_zero;
  logic            sh_load, sh_shift;
  logic [BW-1:0]   bit_q, bit_d;
  logic            last_bit;
  logic            sync_q, sync_d, sclk_q, sclk_d, clr_q, clr_d;
  logic            rdy_q, rdy_d, ldac_q, ldac_d, pend_q, pend_d;

  sdac_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .count    (tmr_cnt),
    .expired  (tmr_zero)
  );

  sdac_shift_out #(.W(WORD_W)) u_shift (
    .clk   (clk),
    .rst   (rst),
    .load  (sh_load),
    .shift (sh_shift),
    .din   (s_data),
    .msb   (dac_sdin)
  );

  assign last_bit    = (bit_q == BW'(WORD_W - 1));
  assign post_len_m1 = ldac_hold_low ? CW'(C_POST_HOLD - 1) : CW'(C_POST_PULSE - 1);
  assign lo_len_m1   = last_bit ? CW'(C_LAST - 1) : CW'(C_LO - 1);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sh_load  = 1'b0;
    sh_shift = 1'b0;
    bit_d    = bit_q;
    sync_d   = sync_q;
    sclk_d   = sclk_q;
    clr_d    = clr_q;
    rdy_d    = rdy_q;
    pend_d   = pend_q | clr_req;

    unique case (state_q)
      ST_IDLE: begin
        rdy_d = 1'b1;
        if (s_valid && rdy_q) begin
          state_d  = ST_SETUP;
          sh_load  = 1'b1;
          sync_d   = 1'b0;
          sclk_d   = 1'b1;
          rdy_d    = 1'b0;
          bit_d    = '0;
          tmr_load = 1'b1;
          tmr_val  = CW'(C_SETUP - 1);
        end else if (pend_d) begin
          state_d  = ST_CLR;
          clr_d    = 1'b0;
          rdy_d    = 1'b0;
          pend_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = CW'(C_CLR - 1);
        end
      end
      ST_SETUP: begin
        if (tmr_zero) begin
          state_d  = ST_SCK_LO;
          sclk_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = lo_len_m1;
        end
      end
      ST_SCK_LO: begin
        if (tmr_zero) begin
          sclk_d   = 1'b1;
          tmr_load = 1'b1;
          if (last_bit) begin
            state_d = ST_POST;
            sync_d  = 1'b1;
            tmr_val = post_len_m1;
          end else begin
            state_d  = ST_SCK_HI;
            sh_shift = 1'b1;
            bit_d    = bit_q + BW'(1);
            tmr_val  = CW'(C_HI - 1);
          end
        end
      end
      ST_SCK_HI: begin
        if (tmr_zero) begin
          state_d  = ST_SCK_LO;
          sclk_d   = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = lo_len_m1;
        end
      end
      ST_POST: begin
        if (tmr_zero) begin
          if (pend_d) begin
            state_d  = ST_CLR;
            clr_d    = 1'b0;
            pend_d   = 1'b0;
            tmr_load = 1'b1;
            tmr_val  = CW'(C_CLR - 1);
          end else begin
            state_d = ST_IDLE;
            rdy_d   = 1'b1;
          end
        end
      end
      ST_CLR: begin
        pend_d = 1'b0;
        if (tmr_zero) begin
          state_d = ST_IDLE;
          clr_d   = 1'b1;
          rdy_d   = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Update strobe follows the post-phase count it will see next cycle.
  always_comb begin
    post_cnt_d = tmr_load ? tmr_val : (tmr_cnt - CW'(1));
    if (ldac_hold_low) begin
      ldac_d = 1'b0;
    end else begin
      ldac_d = !((state_d == ST_POST) && (post_cnt_d >= LD_LO) && (post_cnt_d <= LD_HI));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      bit_q   <= '0;
      sync_q  <= 1'b1;
      sclk_q  <= 1'b1;
      clr_q   <= 1'b1;
      rdy_q   <= 1'b0;
      ldac_q  <= 1'b1;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      bit_q   <= bit_d;
      sync_q  <= sync_d;
      sclk_q  <= sclk_d;
      clr_q   <= clr_d;
      rdy_q   <= rdy_d;
      ldac_q  <= ldac_d;
      pend_q  <= pend_d;
    end
  end

  assign s_ready    = rdy_q;
  assign dac_sync_n = sync_q;
  assign dac_sclk   = sclk_q;
  assign dac_ldac_n = ldac_q;
  assign dac_clr_n  = clr_q;

endmodule

// File: rtl/sdac_wr_ctrl_chk.sv
`timescale 1ns/1ps
module sdac_wr_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic s_valid,
  input logic s_ready,
  input logic ldac_hold_low,
  input logic clr_req,
  input logic dac_sync_n,
  input logic dac_sclk,
  input logic dac_sdin,
  input logic dac_ldac_n,
  input logic dac_clr_n
);

  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (rst)
    dac_sync_n |-> dac_sclk);

  p_sdin_on_rise_r4: assert property (@(posedge clk) disable iff (rst)
    (!dac_sync_n && !$past(dac_sync_n) && (dac_sdin != $past(dac_sdin)))
      |-> (dac_sclk && !$past(dac_sclk)));

  p_ldac_after_sync_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_ldac_n) |-> dac_sync_n);

  p_hold_low_r7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ldac_hold_low && $past(ldac_hold_low)) |-> !dac_ldac_n);

  p_ready_drop_r9: assert property (@(posedge clk) disable iff (rst)
    (s_valid && s_ready) |=> !s_ready);

  p_busy_no_ready_r9: assert property (@(posedge clk) disable iff (rst)
    !dac_sync_n |-> !s_ready);

  p_clr_outside_frame_r10: assert property (@(posedge clk) disable iff (rst)
    $fell(dac_clr_n) |-> (dac_sync_n && !clr_req | dac_sync_n));

endmodule

bind sdac_wr_ctrl sdac_wr_ctrl_chk u_chk (
  .clk           (clk),
  .rst           (rst),
  .s_valid       (s_valid),
  .s_ready       (s_ready),
  .ldac_hold_low (ldac_hold_low),
  .clr_req       (clr_req),
  .dac_sync_n    (dac_sync_n),
  .dac_sclk      (dac_sclk),
  .dac_sdin      (dac_sdin),
  .dac_ldac_n    (dac_ldac_n),
  .dac_clr_n     (dac_clr_n)
);

// File: tb/sdac_wr_ctrl_bench.sv
`timescale 1ns/1ps
module sdac_wr_ctrl_bench;

  logic        clk = 1'b0;
  logic        rst;
  logic        s_valid, s_ready, ldac_hold_low, clr_req;
  logic [15:0] s_data;
  logic        dac_sync_n, dac_sclk, dac_sdin, dac_ldac_n, dac_clr_n;

  always #5 clk = ~clk;

  sdac_wr_ctrl u_sdac_wr_ctrl (
    .clk           (clk),
    .rst           (rst),
    .s_valid       (s_valid),
    .s_data        (s_data),
    .s_ready       (s_ready),
    .ldac_hold_low (ldac_hold_low),
    .clr_req       (clr_req),
    .dac_sync_n    (dac_sync_n),
    .dac_sclk      (dac_sclk),
    .dac_sdin      (dac_sdin),
    .dac_ldac_n    (dac_ldac_n),
    .dac_clr_n     (dac_clr_n)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Receiver model: samples outputs between edges, timestamps every change.
  longint t_sync_rise = -1, t_sync_fall = 0, t_fall = 0, t_rise = 0, t_sdin = 0;
  longint t_ldac_fall = 0, t_ldac_rise = -1, t_ldac_rise_frame = -1, t_clr_fall = 0;
  longint clr_width = 0;
  int     nfall = 0, frames = 0, ldac_pulses = 0, clr_pulses = 0;
  logic [15:0] rx = '0, last_word = '0;
  logic p_sync = 1'b1, p_sclk = 1'b1, p_sdin = 1'b0, p_ldac = 1'b1, p_clr = 1'b1;

  always @(negedge clk) begin
    longint now;
    now = $time;
    if (!rst) begin
      if (p_sync && !dac_sync_n) begin
        if (t_sync_rise >= 0)
          chk(now - t_sync_rise >= 50, "R5 select high gap", now - t_sync_rise, 50);
        if (t_ldac_rise >= 0)
          chk(now - t_ldac_rise >= 5, "R6 update end to select fall", now - t_ldac_rise, 5);
        nfall = 0;
        rx = '0;
        t_sync_fall = now;
        t_sdin = now;
      end
      if (!dac_sync_n && !p_sync && p_sclk && !dac_sclk) begin
        if (nfall == 0) begin
          chk(now - t_sync_fall >= 50, "R3 select lead", now - t_sync_fall, 50);
        end else begin
          chk(now - t_fall == 140, "R2 period", now - t_fall, 140);
          chk(now - t_rise >= 60, "R2 high phase", now - t_rise, 60);
        end
        chk(now - t_sdin >= 40, "R4 data setup", now - t_sdin, 40);
        rx = {rx[14:0], dac_sdin};
        nfall++;
        t_fall = now;
      end
      if (!dac_sync_n && !p_sync && !p_sclk && dac_sclk) begin
        chk(now - t_fall >= 60, "R2 low phase", now - t_fall, 60);
        t_rise = now;
      end
      if ((dac_sdin !== p_sdin) && !dac_sync_n && !p_sync) begin
        chk(!p_sclk && dac_sclk, "R4 data moves with rising edge", dac_sclk, 1);
        chk(now - t_fall >= 15, "R4 data hold", now - t_fall, 15);
        t_sdin = now;
      end
      if (!p_sync && dac_sync_n) begin
        chk(now - t_fall >= 40, "R3 select trail", now - t_fall, 40);
        chk(nfall == 16, "R1 falling edge count", nfall, 16);
        chk(dac_sclk == 1'b1, "R3 clock idles high", dac_sclk, 1);
        last_word = rx;
        frames++;
        t_sync_rise = now;
        t_ldac_rise = -1;
      end
      if (p_ldac && !dac_ldac_n) begin
        chk(dac_sync_n && (now - t_sync_rise >= 5), "R6 update start", now - t_sync_rise, 5);
        t_ldac_fall = now;
      end
      if (!p_ldac && dac_ldac_n) begin
        chk(now - t_ldac_fall >= 50, "R6 update width", now - t_ldac_fall, 50);
        ldac_pulses++;
        t_ldac_rise = now;
        t_ldac_rise_frame = now;
      end
      if (p_clr && !dac_clr_n) begin
        chk(dac_sync_n == 1'b1, "R10 clear outside frame", dac_sync_n, 1);
        t_clr_fall = now;
      end
      if (!p_clr && dac_clr_n) begin
        clr_width = now - t_clr_fall;
        chk(clr_width >= 50, "R8 clear width", clr_width, 50);
        clr_pulses++;
      end
    end
    p_sync = dac_sync_n;
    p_sclk = dac_sclk;
    p_sdin = dac_sdin;
    p_ldac = dac_ldac_n;
    p_clr  = dac_clr_n;
  end

  task automatic wait_ready();
    for (int i = 0; i < 3000 && !s_ready; i++) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] w);
    @(negedge clk);
    s_valid = 1'b1;
    s_data  = w;
    wait_ready();
    @(negedge clk);
    s_valid = 1'b0;
    s_data  = ~w;
    chk(s_ready == 1'b0, "R9 ready drops after accept", s_ready, 0);
  endtask

  // Vector table: {word, hold-low mode}
  localparam int NV = 6;
  localparam logic [16:0] VEC [NV] = '{
    {16'hA5C3, 1'b0},
    {16'h0000, 1'b0},
    {16'hFFFF, 1'b1},
    {16'h8001, 1'b0},
    {16'h7FFE, 1'b1},
    {16'h1234, 1'b0}
  };

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int f0, p0, c0;
    rst = 1'b1;
    s_valid = 1'b0;
    s_data = '0;
    ldac_hold_low = 1'b0;
    clr_req = 1'b0;
    repeat (3) @(negedge clk);
    // R11 reset values
    chk(dac_sync_n == 1'b1, "R11 select in reset", dac_sync_n, 1);
    chk(dac_sclk == 1'b1, "R11 clock in reset", dac_sclk, 1);
    chk(dac_ldac_n == 1'b1, "R11 update in reset", dac_ldac_n, 1);
    chk(dac_clr_n == 1'b1, "R11 clear in reset", dac_clr_n, 1);
    chk(s_ready == 1'b0, "R11 ready in reset", s_ready, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(s_ready == 1'b1, "R11 ready after release", s_ready, 1);

    // Table walk: R1, R6, R7
    for (int v = 0; v < NV; v++) begin
      ldac_hold_low = VEC[v][0];
      repeat (3) @(negedge clk);
      f0 = frames;
      p0 = ldac_pulses;
      send(VEC[v][16:1]);
      wait_ready();
      chk(frames == f0 + 1, "R1 one frame", frames, f0 + 1);
      chk(last_word == VEC[v][16:1], "R1 word", last_word, VEC[v][16:1]);
      if (VEC[v][0]) begin
        chk(ldac_pulses == p0, "R7 no update pulse", ldac_pulses - p0, 0);
        chk(dac_ldac_n == 1'b0, "R7 update held low", dac_ldac_n, 0);
      end else begin
        chk(ldac_pulses == p0 + 1, "R6 one update pulse", ldac_pulses - p0, 1);
      end
    end
    ldac_hold_low = 1'b0;
    repeat (3) @(negedge clk);

    // R9: offer while busy is not taken
    f0 = frames;
    send(16'hC0DE);
    repeat (10) @(negedge clk);
    s_valid = 1'b1;
    s_data = 16'h3333;
    repeat (3) @(negedge clk);
    s_valid = 1'b0;
    wait_ready();
    repeat (40) @(negedge clk);
    chk(frames == f0 + 1, "R9 busy offer ignored", frames, f0 + 1);
    chk(last_word == 16'hC0DE, "R9 word kept", last_word, 16'hC0DE);

    // R8: clear alone
    c0 = clr_pulses;
    @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    chk(s_ready == 1'b0, "R9 busy during clear", s_ready, 0);
    wait_ready();
    @(negedge clk);
    chk(clr_pulses == c0 + 1, "R8 one clear pulse", clr_pulses - c0, 1);
    chk(clr_width == 50, "R8 clear width exact", clr_width, 50);

    // R10: clear in mid-frame
    c0 = clr_pulses;
    send(16'h5A5A);
    repeat (20) @(negedge clk);
    clr_req = 1'b1;
    @(negedge clk);
    clr_req = 1'b0;
    wait_ready();
    @(negedge clk);
    chk(last_word == 16'h5A5A, "R10 frame intact", last_word, 16'h5A5A);
    chk(clr_pulses == c0 + 1, "R10 deferred clear issued", clr_pulses - c0, 1);
    chk(t_clr_fall > t_ldac_rise_frame, "R10 clear after update", t_clr_fall, t_ldac_rise_frame);

    // R10: clear and acceptance in the same cycle
    c0 = clr_pulses;
    f0 = frames;
    @(negedge clk);
    chk(s_ready == 1'b1, "R9 idle ready", s_ready, 1);
    s_valid = 1'b1;
    s_data = 16'h9C3E;
    clr_req = 1'b1;
    @(negedge clk);
    s_valid = 1'b0;
    clr_req = 1'b0;
    wait_ready();
    @(negedge clk);
    chk(frames == f0 + 1, "R10 frame first", frames, f0 + 1);
    chk(last_word == 16'h9C3E, "R10 collided word", last_word, 16'h9C3E);
    chk(clr_pulses == c0 + 1, "R10 collided clear", clr_pulses - c0, 1);
    chk(t_clr_fall > t_sync_rise, "R10 clear after select", t_clr_fall, t_sync_rise);
    chk(t_clr_fall > t_ldac_rise_frame, "R10 clear after pulse", t_clr_fall, t_ldac_rise_frame);

    // R5/R6: back-to-back frames (gap checked by the receiver model)
    send(16'h0F0F);
    send(16'hF0F0);
    wait_ready();
    chk(last_word == 16'hF0F0, "R5 back-to-back word", last_word, 16'hF0F0);

    repeat (5) @(negedge clk);
    finish_run();
  end

endmodule